// File: doc/BRIEF.md
# Weight-Stationary Multiply-Accumulate Cell

This block is one cell of a grid that multiplies matrices with a weight-stationary dataflow. Each cell holds one weight. Activations enter from the left and leave to the right one clock later. Partial sums come down from above, gain one product term in the cell, and leave downward one clock later. A valid flag travels with the activation and with the partial sum. Weights are fed in at the top of each column and move down one row per clock. A weight flag goes with each weight. A cell whose flag is high copies the passing weight into a shadow register. While that happens, the cell keeps computing with its active weight, so the next weight tile loads during the current computation.

A one-cycle swap pulse copies the shadow weight into the active register. The multiply in that same cycle already uses the shadow value. The cell forwards the swap pulse one clock later, to its right-hand neighbour and to the cell below, so activation sweeps diagonally across the grid. Each cell keeps its own column-enable bit, taken from a column count that is broadcast to the whole grid. A disabled cell emits a zero partial sum, keeps both weight registers, and goes on forwarding every traveling signal. A build parameter marks cells in the top row, which ignore the partial-sum input and start from zero.

Top module: `wsa_cell`

## Requirements
- R1: On every clock, `act_out` and `act_valid_out` take the values that `act_in` and `act_valid_in` had before that edge, whether or not the cell is enabled.
- R2: On every clock, `wgt_out` and `wgt_take_out` take the values that `wgt_in` and `wgt_take_in` had before that edge.
- R3: An enabled cell with `wgt_take_in` high copies `wgt_in` into the shadow weight. The active weight does not change, so the product in that cycle uses the previous active weight.
- R4: An enabled cell with `swap_in` high uses the shadow weight for the product in that same cycle, and keeps it as the active weight in later cycles. If a capture happens in the same cycle, the shadow value from before that capture is the one promoted.
- R5: `swap_out` equals `swap_in` delayed by one clock. It feeds both the right-hand and the lower neighbour.
- R6: When enabled, the cell computes a signed Q8.8 result in one clock. The result is the partial sum plus the 32-bit product of activation and effective weight, arithmetically shifted right by 8 and truncated to 16 bits, with two's-complement wrap. `psum_valid_out` then equals the previous `act_valid_in`.
- R7: With `TOP_ROW` = 1, `psum_in` is ignored and the partial-sum base is zero.
- R8: A pulse on `colcnt_load` latches the count on `colcnt_in`. Column mask bit i is set when the count is greater than i, which equals (1 << count) − 1 for counts up to `NUM_COLS`, and larger counts saturate to all ones. The cell is enabled when mask bit `COL_IDX` is set. The new setting applies from the cycle after the load.
- R9: A disabled cell drives `psum_out` = 0 and `psum_valid_out` = 0. It ignores `wgt_take_in` and `swap_in` for its own weights, and still forwards the signals of R1, R2 and R5.
- R10: Synchronous active-high `rst` clears both weight registers and all output registers, and enables the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_in | input | DATA_W | Activation from the left neighbour |
| act_valid_in | input | 1 | Activation valid from the left |
| act_out | output | DATA_W | Activation to the right neighbour |
| act_valid_out | output | 1 | Activation valid to the right |
| wgt_in | input | DATA_W | Weight from above |
| wgt_take_in | input | 1 | Capture flag for the weight from above |
| wgt_out | output | DATA_W | Weight to the cell below |
| wgt_take_out | output | 1 | Capture flag to the cell below |
| swap_in | input | 1 | Shadow-to-active promote pulse |
| swap_out | output | 1 | Promote pulse to right and lower neighbours |
| psum_in | input | DATA_W | Partial sum from above |
| psum_out | output | DATA_W | Updated partial sum downward |
| psum_valid_out | output | 1 | Partial sum valid |
| colcnt_in | input | CNT_W | Number of enabled columns |
| colcnt_load | input | 1 | Strobe that latches `colcnt_in` |

## Verification
Every result of this cell is due exactly one clock after its stimulus. The bench drives inputs on the falling edge and reads outputs on the next falling edge, after the single rising edge that registers them. The enable bit needs one clock of its own: a column-count load is placed in its own cycle, and the first stimulus that depends on it is driven one clock later. A swap is driven in the same cycle as the activation it affects, because the promoted weight is used without delay. A weight capture is checked by a multiply that follows it, and the check expects the old weight until a swap occurs.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

   // Default geometry for a cell of the multiply grid.
   localparam int DEF_DATA_W = 16;
   localparam int DEF_FRAC_W = 8;
   localparam int DEF_CNT_W  = 16;
   localparam int DEF_COLS   = 2;

   // Action taken on the weight bank in one cycle.
   typedef enum logic [1:0] {
      WB_HOLD = 2'b00,
      WB_LOAD = 2'b01,
      WB_SWAP = 2'b10,
      WB_BOTH = 2'b11
   } wb_op_e;

endpackage

// File: rtl/wsa_colmask.sv
module wsa_colmask #(
   parameter int NUM_COLS = wsa_pkg::DEF_COLS,
   parameter int CNT_W    = wsa_pkg::DEF_CNT_W,
   parameter int COL_IDX  = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             cnt_load,
   output logic             col_en
);

   localparam logic [CNT_W-1:0] IDX_C = CNT_W'(COL_IDX);

   initial begin
      assert (COL_IDX >= 0 && COL_IDX < NUM_COLS)
         else $error("wsa_colmask: COL_IDX out of range");
      assert (CNT_W >= 1) else $error("wsa_colmask: CNT_W too small");
   end

   // This column's bit of the mask: count above index.
   logic en_q;

   always_ff @(posedge clk) begin
      if (rst)           en_q <= 1'b1;
      else if (cnt_load) en_q <= (cnt_in > IDX_C);
   end

   assign col_en = en_q;

   // R8: a load sets the bit from the count; otherwise it holds
   assert_mask_load_R8: assert property (@(posedge clk) disable iff (rst)
      cnt_load |=> (col_en == ($past(cnt_in) > IDX_C)));
   assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !cnt_load |=> $stable(col_en));

endmodule

// File: rtl/wsa_wbank.sv
module wsa_wbank #(
   parameter int DATA_W = wsa_pkg::DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              take,
   input  logic              swap,
   input  logic [DATA_W-1:0] wgt_in,
   output logic [DATA_W-1:0] eff_wgt
);
   import wsa_pkg::*;

   logic [DATA_W-1:0] shadow_q, active_q;
   wb_op_e            op;

   always_comb begin
      if (!en)              op = WB_HOLD;
      else if (take && swap) op = WB_BOTH;
      else if (swap)        op = WB_SWAP;
      else if (take)        op = WB_LOAD;
      else                  op = WB_HOLD;
   end

   // Promoted weight is used with no added cycle.
   assign eff_wgt = (op == WB_SWAP || op == WB_BOTH) ? shadow_q : active_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
         active_q <= '0;
      end else begin
         unique case (op)
            WB_LOAD: shadow_q <= wgt_in;
            WB_SWAP: active_q <= shadow_q;
            WB_BOTH: begin
               active_q <= shadow_q;
               shadow_q <= wgt_in;
            end
            default: ;
         endcase
      end
   end

   // R3: capture only when enabled and flagged
   assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !(en && take) |=> $stable(shadow_q));
   assert_shadow_take_R3: assert property (@(posedge clk) disable iff (rst)
      (en && take) |=> shadow_q == $past(wgt_in));
   // R4: promote copies the old shadow
   assert_promote_R4: assert property (@(posedge clk) disable iff (rst)
      (en && swap) |=> active_q == $past(shadow_q));
   // R9: disabled cell keeps its active weight
   assert_active_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !(en && swap) |=> $stable(active_q));

endmodule

// File: rtl/wsa_mac.sv
module wsa_mac #(
   parameter int DATA_W  = wsa_pkg::DEF_DATA_W,
   parameter int FRAC_W  = wsa_pkg::DEF_FRAC_W,
   parameter bit TOP_ROW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              valid_in,
   input  logic [DATA_W-1:0] act,
   input  logic [DATA_W-1:0] wgt,
   input  logic [DATA_W-1:0] psum_in,
   output logic [DATA_W-1:0] psum_out,
   output logic              valid_out
);

   localparam int PROD_W = 2 * DATA_W;

   initial begin
      assert (DATA_W >= 2) else $error("wsa_mac: DATA_W too small");
      assert (FRAC_W >= 0 && FRAC_W < DATA_W)
         else $error("wsa_mac: FRAC_W must be below DATA_W");
   end

   logic [DATA_W-1:0]        base;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;
   logic [DATA_W-1:0]        sum;

   generate
      if (TOP_ROW) begin : g_top
         logic unused_psum;
         assign unused_psum = ^psum_in;
         assign base = '0;
      end else begin : g_inner
         assign base = psum_in;
      end
   endgenerate

   assign prod   = $signed(act) * $signed(wgt);
   assign scaled = prod >>> FRAC_W;
   assign sum    = base + scaled[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         psum_out  <= '0;
         valid_out <= 1'b0;
      end else if (en) begin
         psum_out  <= sum;
         valid_out <= valid_in;
      end else begin
         psum_out  <= '0;
         valid_out <= 1'b0;
      end
   end

   // R9: disabled cell emits zero, not valid
   assert_disabled_zero_R9: assert property (@(posedge clk) disable iff (rst)
      !en |=> (psum_out == '0) && !valid_out);
   // R6: valid follows the activation valid
   assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
      en |=> valid_out == $past(valid_in));

endmodule

// File: rtl/wsa_cell.sv
module wsa_cell #(
   parameter int DATA_W   = wsa_pkg::DEF_DATA_W,
   parameter int FRAC_W   = wsa_pkg::DEF_FRAC_W,
   parameter int CNT_W    = wsa_pkg::DEF_CNT_W,
   parameter int NUM_COLS = wsa_pkg::DEF_COLS,
   parameter int COL_IDX  = 0,
   parameter bit TOP_ROW  = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] act_in,
   input  logic              act_valid_in,
   output logic [DATA_W-1:0] act_out,
   output logic              act_valid_out,
   input  logic [DATA_W-1:0] wgt_in,
   input  logic              wgt_take_in,
   output logic [DATA_W-1:0] wgt_out,
   output logic              wgt_take_out,
   input  logic              swap_in,
   output logic              swap_out,
   input  logic [DATA_W-1:0] psum_in,
   output logic [DATA_W-1:0] psum_out,
   output logic              psum_valid_out,
   input  logic [CNT_W-1:0]  colcnt_in,
   input  logic              colcnt_load
);

   logic              col_en;
   logic [DATA_W-1:0] eff_wgt;

   wsa_colmask #(
      .NUM_COLS (NUM_COLS),
      .CNT_W    (CNT_W),
      .COL_IDX  (COL_IDX)
   ) u_mask (
      .clk      (clk),
      .rst      (rst),
      .cnt_in   (colcnt_in),
      .cnt_load (colcnt_load),
      .col_en   (col_en)
   );

   wsa_wbank #(
      .DATA_W (DATA_W)
   ) u_wbank (
      .clk     (clk),
      .rst     (rst),
      .en      (col_en),
      .take    (wgt_take_in),
      .swap    (swap_in),
      .wgt_in  (wgt_in),
      .eff_wgt (eff_wgt)
   );

   wsa_mac #(
      .DATA_W  (DATA_W),
      .FRAC_W  (FRAC_W),
      .TOP_ROW (TOP_ROW)
   ) u_mac (
      .clk       (clk),
      .rst       (rst),
      .en        (col_en),
      .valid_in  (act_valid_in),
      .act       (act_in),
      .wgt       (eff_wgt),
      .psum_in   (psum_in),
      .psum_out  (psum_out),
      .valid_out (psum_valid_out)
   );

   // Forwarding stage: runs regardless of the enable.
   always_ff @(posedge clk) begin
      if (rst) begin
         act_out       <= '0;
         act_valid_out <= 1'b0;
         wgt_out       <= '0;
         wgt_take_out  <= 1'b0;
         swap_out      <= 1'b0;
      end else begin
         act_out       <= act_in;
         act_valid_out <= act_valid_in;
         wgt_out       <= wgt_in;
         wgt_take_out  <= wgt_take_in;
         swap_out      <= swap_in;
      end
   end

   assert_act_fwd_R1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (act_out == $past(act_in)) && (act_valid_out == $past(act_valid_in)));
   assert_wgt_fwd_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (wgt_out == $past(wgt_in)) && (wgt_take_out == $past(wgt_take_in)));
   assert_swap_fwd_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> swap_out == $past(swap_in));
   // R10: reset leaves all outputs cleared
   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (psum_out == '0) && !psum_valid_out && !swap_out && !act_valid_out);

endmodule

// File: tb/tb_wsa_cell.sv
module tb_wsa_cell;

   typedef struct packed {
      logic [15:0] act;
      logic [15:0] wgt;
      logic [15:0] ps;
      logic [15:0] exp_sum;
      logic [15:0] exp_prod;
   } vec_t;

   // act, weight, psum in, expected sum, expected product-only (top row)
   localparam vec_t VEC [6] = '{
      '{16'h0100, 16'h0200, 16'h0000, 16'h0200, 16'h0200},
      '{16'hFF00, 16'h0300, 16'h0100, 16'hFE00, 16'hFD00},
      '{16'h0080, 16'h0080, 16'h0000, 16'h0040, 16'h0040},
      '{16'h7FFF, 16'h0100, 16'h0001, 16'h8000, 16'h7FFF},
      '{16'hFFFF, 16'h0080, 16'h0010, 16'h000F, 16'hFFFF},
      '{16'h4000, 16'h0400, 16'h1234, 16'h1234, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] act_in = '0;
   logic        act_valid_in = 1'b0;
   logic [15:0] wgt_in = '0;
   logic        wgt_take_in = 1'b0;
   logic        swap_in = 1'b0;
   logic [15:0] psum_in = '0;
   logic [15:0] colcnt_in = '0;
   logic        colcnt_load = 1'b0;

   logic [15:0] act_out, wgt_out, psum_out, t_act_out, t_wgt_out, t_psum_out;
   logic        act_valid_out, wgt_take_out, swap_out, psum_valid_out;
   logic        t_act_valid_out, t_wgt_take_out, t_swap_out, t_psum_valid_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   // Inner cell in column 1
   wsa_cell #(.COL_IDX(1), .TOP_ROW(1'b0)) dut (
      .clk(clk), .rst(rst),
      .act_in(act_in), .act_valid_in(act_valid_in),
      .act_out(act_out), .act_valid_out(act_valid_out),
      .wgt_in(wgt_in), .wgt_take_in(wgt_take_in),
      .wgt_out(wgt_out), .wgt_take_out(wgt_take_out),
      .swap_in(swap_in), .swap_out(swap_out),
      .psum_in(psum_in), .psum_out(psum_out), .psum_valid_out(psum_valid_out),
      .colcnt_in(colcnt_in), .colcnt_load(colcnt_load)
   );

   // Top-row cell in column 0
   wsa_cell #(.COL_IDX(0), .TOP_ROW(1'b1)) dut_top (
      .clk(clk), .rst(rst),
      .act_in(act_in), .act_valid_in(act_valid_in),
      .act_out(t_act_out), .act_valid_out(t_act_valid_out),
      .wgt_in(wgt_in), .wgt_take_in(wgt_take_in),
      .wgt_out(t_wgt_out), .wgt_take_out(t_wgt_take_out),
      .swap_in(swap_in), .swap_out(t_swap_out),
      .psum_in(psum_in), .psum_out(t_psum_out), .psum_valid_out(t_psum_valid_out),
      .colcnt_in(colcnt_in), .colcnt_load(colcnt_load)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      act_valid_in = 1'b0; wgt_take_in = 1'b0; swap_in = 1'b0;
      colcnt_load = 1'b0;  psum_in = '0;
   endtask

   task automatic set_count(input logic [15:0] n);
      idle();
      colcnt_in = n; colcnt_load = 1'b1;
      tick();
      colcnt_load = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      act_in = 16'hAAAA; act_valid_in = 1'b1; wgt_in = 16'h5555;
      wgt_take_in = 1'b1; swap_in = 1'b1; psum_in = 16'h1111;
      tick(); tick();
      // R10: outputs cleared while reset held
      check("R10 psum", psum_out, 16'h0);
      check("R10 valid", {15'b0, psum_valid_out}, 16'h0);
      check("R10 act fwd", act_out, 16'h0);
      check("R10 ctrl fwd", {13'b0, act_valid_out, wgt_take_out, swap_out}, 16'h0);
      check("R10 wgt fwd", wgt_out, 16'h0);
      idle(); rst = 1'b0;
      tick();

      // R10: active weight zero after reset, so result is psum_in
      act_in = 16'h0100; act_valid_in = 1'b1; psum_in = 16'h0005;
      tick();
      check("R10 zero weight sum", psum_out, 16'h0005);
      check("R10 enabled after reset", {15'b0, psum_valid_out}, 16'h1);
      idle(); tick();

      // Table walk: capture, then swap with compute in the same cycle
      for (int i = 0; i < 6; i++) begin
         wgt_in = VEC[i].wgt; wgt_take_in = 1'b1;
         tick();
         check("R2 wgt fwd", wgt_out, VEC[i].wgt);
         check("R2 take fwd", {15'b0, wgt_take_out}, 16'h1);
         wgt_take_in = 1'b0; swap_in = 1'b1;
         act_in = VEC[i].act; act_valid_in = 1'b1; psum_in = VEC[i].ps;
         tick();
         check("R4 R6 sum", psum_out, VEC[i].exp_sum);
         check("R6 valid", {15'b0, psum_valid_out}, 16'h1);
         check("R7 top row product", t_psum_out, VEC[i].exp_prod);
         check("R5 swap fwd", {15'b0, swap_out}, 16'h1);
         check("R1 act fwd", act_out, VEC[i].act);
         check("R1 valid fwd", {15'b0, act_valid_out}, 16'h1);
         idle();
         tick();
         check("R5 swap drop", {15'b0, swap_out}, 16'h0);
      end

      // R3: capture keeps using the old active weight (0x0400)
      wgt_in = 16'h0100; wgt_take_in = 1'b1;
      act_in = 16'h0100; act_valid_in = 1'b1; psum_in = 16'h0000;
      tick();
      check("R3 old weight during capture", psum_out, 16'h0400);
      wgt_take_in = 1'b0; swap_in = 1'b1;
      tick();
      check("R4 same-cycle promote", psum_out, 16'h0100);
      swap_in = 1'b0;
      tick();
      check("R4 promoted weight kept", psum_out, 16'h0100);
      // shadow now 0x0200, active 0x0100
      idle(); wgt_in = 16'h0200; wgt_take_in = 1'b1;
      tick();

      // R8 R9: count 1 disables column 1 only
      set_count(16'd1);
      wgt_in = 16'h0300; wgt_take_in = 1'b1; swap_in = 1'b1;
      act_in = 16'h0200; act_valid_in = 1'b1; psum_in = 16'h0007;
      tick();
      check("R9 disabled psum", psum_out, 16'h0);
      check("R9 disabled valid", {15'b0, psum_valid_out}, 16'h0);
      check("R9 act still fwd", act_out, 16'h0200);
      check("R9 wgt still fwd", wgt_out, 16'h0300);
      check("R9 swap still fwd", {15'b0, swap_out}, 16'h1);
      check("R8 column 0 enabled", {15'b0, t_psum_valid_out}, 16'h1);
      set_count(16'd2);
      act_in = 16'h0100; act_valid_in = 1'b1;
      tick();
      check("R9 active weight held", psum_out, 16'h0100);
      swap_in = 1'b1;
      tick();
      check("R9 shadow weight held", psum_out, 16'h0200);
      idle(); tick();

      // R8: count 0 disables both, count 5 saturates to all
      set_count(16'd0);
      act_in = 16'h0100; act_valid_in = 1'b1;
      tick();
      check("R8 count0 col1", {15'b0, psum_valid_out}, 16'h0);
      check("R8 count0 col0", {15'b0, t_psum_valid_out}, 16'h0);
      set_count(16'd5);
      act_valid_in = 1'b1;
      tick();
      check("R8 count5 col1", {15'b0, psum_valid_out}, 16'h1);
      check("R8 count5 col0", {15'b0, t_psum_valid_out}, 16'h1);

      // R10: mid-run reset clears weights and re-enables
      set_count(16'd0);
      rst = 1'b1; act_valid_in = 1'b1; swap_in = 1'b1;
      tick();
      check("R10 mid reset psum", psum_out, 16'h0);
      check("R10 mid reset swap", {15'b0, swap_out}, 16'h0);
      rst = 1'b0; idle();
      act_in = 16'h0100; act_valid_in = 1'b1; psum_in = 16'h0009;
      tick();
      check("R10 weights cleared", psum_out, 16'h0009);
      check("R10 mask reset to enabled", {15'b0, psum_valid_out}, 16'h1);
      idle(); tick();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule